// File: doc/BRIEF.md
# Audio Serial Transmitter with Selectable Framing

This block is the transmit side of a master audio serial port. It takes a left/right pair of parallel samples through a valid/ready handshake. From these it produces a bit clock, a word-select or frame-sync line and a serial data line. A single shift engine covers four framings: the classic two-channel I2S framing, a left-aligned variant, a right-aligned variant and a PCM framing with one sample per frame. PCM framing supports a short or a long sync pulse.

The framing, the resting clock level, the sample width, the channel slot width and the bit-clock divider are loaded through a small configuration port. A load only takes effect while the block is disabled. Software sets the port up while `en` is low, then raises `en` to start a continuous stream of frames. Samples arrive right-aligned in a 32-bit word. When no sample is waiting at the start of a frame, the frame carries zeros.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset `sck`, `ws`, `sd` and `cfg_err` are 0 and `s_ready` is 1. The reset configuration is I2S framing, 16-bit data, 16-bit channels, resting level low and a half period of one system clock.
- R2: A configuration load (`cfg_wr` high) is accepted only when `en` is low. A load while `en` is high leaves framing, polarity, lengths and divider unchanged.
- R3: A load with `cfg_dlen` = 11 is refused and sets `cfg_err`, and the stored configuration stays as it was. The next accepted load clears `cfg_err`.
- R4: While disabled, `sck` rests at the stored polarity bit (0 = low, 1 = high). While enabled, `ws` and `sd` change only on the `sck` edge that leaves the non-resting level. That edge is falling for polarity 0 and rising for polarity 1.
- R5: Each `sck` level lasts `cfg_half` system clocks, and a value of 0 counts as 1. The first edge after enabling comes `cfg_half` clocks after the first enabled cycle.
- R6: The data length codes are 00 = 16, 01 = 24 and 10 = 32 bits. The channel slot is 32 bits whenever the data length is 24 or 32. With 16-bit data, `cfg_chlen` picks 16 (0) or 32 (1).
- R7: Code 00 selects I2S framing. `ws` is 0 for the left slot and 1 for the right slot, and each sample's MSB is sent one bit period after the `ws` change.
- R8: Code 01 selects left-aligned framing. `ws` is 0 for left and 1 for right, the MSB is sent in the first bit of the slot, and the bits after the LSB are 0.
- R9: Code 10 selects right-aligned framing. `ws` is 0 for left and 1 for right, the LSB is sent in the last bit of the slot, and the leading bits are 0.
- R10: Code 11 with the sync bit at 0 selects PCM short sync. A frame is one slot carrying the left sample MSB first, the right input is ignored, and `ws` is high only during the last bit period of each frame.
- R11: Code 11 with the sync bit at 1 selects PCM long sync. `ws` is high for the first 13 bit periods of each frame, starting with the MSB.
- R12: `s_ready` is high exactly when the one-entry holding buffer is empty. A frame start takes the buffered pair, and with an empty buffer that frame carries all-zero data.
- R13: Only the low data-length bits of `s_left`/`s_right` are sent, MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Enable; low stops the stream and opens the configuration |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_fmt | input | 2 | Framing: 00 I2S, 01 left-aligned, 10 right-aligned, 11 PCM |
| cfg_pcm_long | input | 1 | PCM sync: 0 short, 1 long |
| cfg_cpol | input | 1 | Resting level of `sck` |
| cfg_dlen | input | 2 | Data length code |
| cfg_chlen | input | 1 | Channel slot width for 16-bit data |
| cfg_half | input | DIV_W | Half bit period in system clocks |
| s_valid | input | 1 | Sample pair valid |
| s_left | input | 32 | Left sample, right-aligned |
| s_right | input | 32 | Right sample, right-aligned |
| s_ready | output | 1 | Holding buffer empty |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select or frame sync |
| sd | output | 1 | Serial data |
| cfg_err | output | 1 | Last refused load had an illegal length code |

## Verification
Two situations are the hardest to reach from the ports. The first is the bit that I2S framing carries across a frame boundary: the LSB of one frame's right sample is sent in the first slot of the next frame. That bit only shows up when frames run back to back with fresh samples. The bench therefore keeps a feeder presenting a new pair after every accepted one and runs several consecutive frames per mode. The second is a load while enabled. This is exposed only by disabling afterwards and watching the resting clock level, so the bench writes an opposite polarity mid-stream and then checks `sck` after the stream stops.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    typedef enum logic [1:0] {
        FMT_PHIL = 2'd0,
        FMT_MSBJ = 2'd1,
        FMT_LSBJ = 2'd2,
        FMT_PCM  = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic       pcm_long;
        logic       cpol;
        logic [1:0] dlen;
        logic       chlen;
    } ser_cfg_t;

    localparam logic [1:0] DLEN_BAD = 2'b11;

endpackage

// File: rtl/aud_ser_bclk.sv
module aud_ser_bclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             bclk,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } st_t;

    st_t              st_d, st_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        fall = 1'b0;
        lim  = (half == '0) ? DIV_W'(1) : half;
        if (!run) begin
            st_d = '0;
        end else if (st_q.cnt == lim - DIV_W'(1)) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
            fall     = st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk = st_q.lvl;

endmodule

// File: rtl/aud_ser_frame.sv
module aud_ser_frame
    import aud_ser_pkg::*;
#(
    parameter int SMP_W     = 32,
    parameter int LONG_SYNC = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fall,
    input  ser_cfg_t         cfg,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_left,
    input  logic [SMP_W-1:0] s_right,
    output logic             s_ready,
    output logic             ws,
    output logic             sd
);
    localparam int SLOT_W = $clog2(2 * SMP_W);
    localparam int IDX_W  = $clog2(SMP_W);
    localparam logic [SLOT_W-1:0] CH_S = SLOT_W'(SMP_W / 2);
    localparam logic [SLOT_W-1:0] CH_L = SLOT_W'(SMP_W);
    localparam logic [SLOT_W-1:0] DL_S = SLOT_W'(SMP_W / 2);
    localparam logic [SLOT_W-1:0] DL_M = SLOT_W'(SMP_W * 3 / 4);
    localparam logic [SLOT_W-1:0] DL_L = SLOT_W'(SMP_W);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              fresh;
        logic [SMP_W-1:0]  cur_l;
        logic [SMP_W-1:0]  cur_r;
        logic [SMP_W-1:0]  buf_l;
        logic [SMP_W-1:0]  buf_r;
        logic              buf_full;
        logic              dly;
        logic              ws;
        logic              sd;
    } st_t;

    st_t               st_d, st_q;
    logic [SLOT_W-1:0] chl, dl, last, k, pos, idx;
    logic [SLOT_W:0]   flen;
    logic [SMP_W-1:0]  smp;
    logic              right, hit, bitv;

    always_comb begin
        st_d  = st_q;
        chl   = (cfg.dlen != 2'd0 || cfg.chlen) ? CH_L : CH_S;
        unique case (cfg.dlen)
            2'd0:    dl = DL_S;
            2'd1:    dl = DL_M;
            default: dl = DL_L;
        endcase
        flen  = (cfg.fmt == FMT_PCM) ? {1'b0, chl} : {chl, 1'b0};
        last  = SLOT_W'(flen - 1'b1);
        k     = '0;
        pos   = '0;
        idx   = '0;
        smp   = '0;
        right = 1'b0;
        hit   = 1'b0;
        bitv  = 1'b0;

        if (!run) begin
            st_d.slot  = '0;
            st_d.fresh = 1'b1;
            st_d.ws    = 1'b0;
            st_d.sd    = 1'b0;
            st_d.dly   = 1'b0;
        end else if (fall) begin
            k          = (st_q.fresh || st_q.slot == last) ? '0 : st_q.slot + 1'b1;
            st_d.fresh = 1'b0;
            st_d.slot  = k;
            if (k == '0) begin
                if (st_q.buf_full) begin
                    st_d.cur_l    = st_q.buf_l;
                    st_d.cur_r    = st_q.buf_r;
                    st_d.buf_full = 1'b0;
                end else begin
                    st_d.cur_l = '0;
                    st_d.cur_r = '0;
                end
            end
            right = (cfg.fmt != FMT_PCM) && (k >= chl);
            pos   = right ? k - chl : k;
            smp   = right ? st_d.cur_r : st_d.cur_l;
            if (cfg.fmt == FMT_LSBJ) begin
                idx = chl - 1'b1 - pos;
                hit = idx < dl;
            end else begin
                idx = dl - 1'b1 - pos;
                hit = pos < dl;
            end
            bitv      = hit & smp[idx[IDX_W-1:0]];
            st_d.sd   = (cfg.fmt == FMT_PHIL) ? st_q.dly : bitv;
            st_d.dly  = bitv;
            if (cfg.fmt == FMT_PCM)
                st_d.ws = cfg.pcm_long ? (k < SLOT_W'(LONG_SYNC)) : (k == chl - 1'b1);
            else
                st_d.ws = right;
        end

        if (s_valid && !st_q.buf_full) begin
            st_d.buf_l    = s_left;
            st_d.buf_r    = s_right;
            st_d.buf_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fresh <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_ready = ~st_q.buf_full;
    assign ws      = st_q.ws;
    assign sd      = st_q.sd;

    // R4: serial outputs only move on the launching bit-clock edge
    p_hold_between_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && !fall |=> $stable(sd) && $stable(ws));

    // R12: an accepted pair fills the buffer, so ready drops
    p_ready_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && s_ready |=> !s_ready);

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_fmt,
    input  logic             cfg_pcm_long,
    input  logic             cfg_cpol,
    input  logic [1:0]       cfg_dlen,
    input  logic             cfg_chlen,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_left,
    input  logic [SMP_W-1:0] s_right,
    output logic             s_ready,
    output logic             sck,
    output logic             ws,
    output logic             sd,
    output logic             cfg_err
);
    typedef struct packed {
        ser_cfg_t         cfg;
        logic [DIV_W-1:0] half;
        logic             err;
    } st_t;

    st_t  st_d, st_q;
    logic bclk, fall;

    always_comb begin
        st_d = st_q;
        if (cfg_wr && !en) begin
            if (cfg_dlen == DLEN_BAD) begin
                st_d.err = 1'b1;
            end else begin
                st_d.cfg.fmt      = fmt_e'(cfg_fmt);
                st_d.cfg.pcm_long = cfg_pcm_long;
                st_d.cfg.cpol     = cfg_cpol;
                st_d.cfg.dlen     = cfg_dlen;
                st_d.cfg.chlen    = cfg_chlen;
                st_d.half         = cfg_half;
                st_d.err          = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.half <= DIV_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    aud_ser_bclk #(.DIV_W(DIV_W)) bclk_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en),
        .half (st_q.half),
        .bclk (bclk),
        .fall (fall)
    );

    aud_ser_frame #(.SMP_W(SMP_W)) frame_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en),
        .fall   (fall),
        .cfg    (st_q.cfg),
        .s_valid(s_valid),
        .s_left (s_left),
        .s_right(s_right),
        .s_ready(s_ready),
        .ws     (ws),
        .sd     (sd)
    );

    assign sck     = bclk ^ st_q.cfg.cpol;
    assign cfg_err = st_q.err;

    // R2: settings cannot move while streaming
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(st_q.cfg) && $stable(st_q.half));

    // R3: illegal length code is flagged and not stored
    p_bad_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !en && cfg_dlen == DLEN_BAD |=> cfg_err && $stable(st_q.cfg));

    // R4: bit clock rests at the stored polarity while disabled
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> sck == st_q.cfg.cpol);

endmodule

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_fmt = 2'd0;
    logic             cfg_pcm_long = 1'b0;
    logic             cfg_cpol = 1'b0;
    logic [1:0]       cfg_dlen = 2'd0;
    logic             cfg_chlen = 1'b0;
    logic [DIV_W-1:0] cfg_half = 8'd1;
    logic             s_valid = 1'b0;
    logic [31:0]      s_left = '0;
    logic [31:0]      s_right = '0;
    logic             s_ready, sck, ws, sd, cfg_err;

    always #2 clk = ~clk;

    aud_ser_tx #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt),
        .cfg_pcm_long(cfg_pcm_long), .cfg_cpol(cfg_cpol), .cfg_dlen(cfg_dlen),
        .cfg_chlen(cfg_chlen), .cfg_half(cfg_half), .s_valid(s_valid),
        .s_left(s_left), .s_right(s_right), .s_ready(s_ready), .sck(sck),
        .ws(ws), .sd(sd), .cfg_err(cfg_err)
    );

    int    total = 0, bad = 0;
    string tg = "R1";
    bit    done = 1'b0;
    bit    feed_on = 1'b1;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_fmt, m_long, m_cpol, m_dlen, m_chlen, m_half, m_err, m_cnt;
    bit  m_bclk, m_full, m_ws, m_sd, m_carry, m_acc;
    logic [31:0] m_bl, m_br;
    bit  qws[$];
    bit  qsd[$];

    function automatic void build_frame(logic [31:0] l, logic [31:0] r);
        int c, d, nch;
        bit mj[$];
        logic [31:0] smp;
        c   = (m_dlen != 0 || m_chlen != 0) ? 32 : 16;
        d   = (m_dlen == 0) ? 16 : (m_dlen == 1) ? 24 : 32;
        nch = (m_fmt == 3) ? 1 : 2;
        for (int ch = 0; ch < nch; ch++) begin
            smp = (ch == 1) ? r : l;
            for (int p = 0; p < c; p++) begin
                bit b;
                b = 1'b0;
                if (m_fmt == 2) begin
                    if (p >= c - d) b = smp[d - 1 - (p - (c - d))];
                end else if (p < d) begin
                    b = smp[d - 1 - p];
                end
                mj.push_back(b);
                if (m_fmt == 3) qws.push_back((m_long != 0) ? (p < 13) : (p == c - 1));
                else            qws.push_back(ch == 1);
            end
        end
        if (m_fmt == 0) begin
            qsd.push_back(m_carry);
            for (int i = 0; i < mj.size() - 1; i++) qsd.push_back(mj[i]);
            m_carry = mj[mj.size() - 1];
        end else begin
            for (int i = 0; i < mj.size(); i++) qsd.push_back(mj[i]);
        end
    endfunction

    always @(posedge clk) begin
        bit acc;
        int lim;
        if (!rst_n) begin
            m_fmt = 0; m_long = 0; m_cpol = 0; m_dlen = 0; m_chlen = 0; m_half = 1;
            m_err = 0; m_cnt = 0; m_bclk = 0; m_full = 0; m_ws = 0; m_sd = 0;
            m_carry = 0; m_acc = 0; qws.delete(); qsd.delete();
        end else begin
            acc = s_valid && !m_full;
            lim = (m_half == 0) ? 1 : m_half;
            if (!en) begin
                m_cnt = 0; m_bclk = 0; m_ws = 0; m_sd = 0; m_carry = 0;
                qws.delete(); qsd.delete();
            end else if (m_cnt == lim - 1) begin
                m_cnt = 0;
                if (m_bclk) begin
                    m_bclk = 0;
                    if (qsd.size() == 0) begin
                        if (m_full) begin
                            build_frame(m_bl, m_br);
                            m_full = 0;
                        end else begin
                            build_frame(32'd0, 32'd0);
                        end
                    end
                    m_ws = qws.pop_front();
                    m_sd = qsd.pop_front();
                end else begin
                    m_bclk = 1;
                end
            end else begin
                m_cnt++;
            end
            if (cfg_wr && !en) begin
                if (cfg_dlen == 2'b11) m_err = 1;
                else begin
                    m_fmt = cfg_fmt; m_long = cfg_pcm_long; m_cpol = cfg_cpol;
                    m_dlen = cfg_dlen; m_chlen = cfg_chlen; m_half = cfg_half; m_err = 0;
                end
            end
            if (acc) begin
                m_bl = s_left; m_br = s_right; m_full = 1;
            end
            m_acc = acc;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 R5 sck", {31'd0, sck}, {31'd0, m_bclk ^ m_cpol[0]});
            chk({tg, " ws"}, {31'd0, ws}, {31'd0, m_ws});
            chk({tg, " sd"}, {31'd0, sd}, {31'd0, m_sd});
            chk("R12 s_ready", {31'd0, s_ready}, {31'd0, !m_full});
            chk("R3 cfg_err", {31'd0, cfg_err}, {31'd0, m_err[0]});
        end
    end

    // sample feeder: new pair after each acceptance
    always @(negedge clk) begin
        if (rst_n) begin
            s_valid <= feed_on;
            if (m_acc) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                s_left <= lcg;
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                s_right <= lcg;
            end
        end
    end

    task automatic load_cfg(int f, int lg, int cp, int dl, int ch, int hf);
        @(negedge clk);
        cfg_fmt = 2'(f); cfg_pcm_long = 1'(lg); cfg_cpol = 1'(cp);
        cfg_dlen = 2'(dl); cfg_chlen = 1'(ch); cfg_half = DIV_W'(hf);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_mode(int f, int lg, int cp, int dl, int ch, int hf, string t);
        int cyc;
        en = 1'b0;
        load_cfg(f, lg, cp, dl, ch, hf);
        tg  = t;
        cyc = 3 * 64 * 2 * ((hf == 0) ? 1 : hf) + 20;
        en  = 1'b1;
        repeat (cyc) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state (outputs before any enable)
        chk("R1 ws", {31'd0, ws}, 32'd0);
        chk("R1 sd", {31'd0, sd}, 32'd0);
        chk("R1 sck", {31'd0, sck}, 32'd0);
        chk("R1 s_ready", {31'd0, s_ready}, 32'd1);
        chk("R1 cfg_err", {31'd0, cfg_err}, 32'd0);

        run_mode(0, 0, 0, 0, 0, 2, "R7 R13");
        run_mode(0, 0, 0, 2, 0, 1, "R7 R6");
        run_mode(1, 0, 1, 1, 0, 1, "R8 R6 R13");
        run_mode(2, 0, 0, 0, 1, 3, "R9 R6");
        run_mode(2, 0, 0, 1, 0, 0, "R9 R13 R5");
        run_mode(3, 0, 0, 0, 0, 2, "R10");
        run_mode(3, 1, 0, 2, 0, 1, "R11");
        feed_on = 1'b0;
        run_mode(1, 0, 0, 0, 0, 1, "R12");
        feed_on = 1'b1;

        // R2: load while streaming must not take effect
        load_cfg(1, 0, 0, 0, 0, 1);
        tg = "R2";
        en = 1'b1;
        repeat (100) @(negedge clk);
        cfg_fmt = 2'd3; cfg_cpol = 1'b1; cfg_dlen = 2'd2; cfg_half = 8'd4; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (200) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R2 idle level kept old polarity", {31'd0, sck}, 32'd0);

        // R3: illegal length is refused and flagged
        load_cfg(0, 0, 1, 3, 0, 1);
        chk("R3 error flagged", {31'd0, cfg_err}, 32'd1);
        chk("R3 polarity not stored", {31'd0, sck}, 32'd0);
        load_cfg(0, 0, 1, 0, 0, 1);
        chk("R3 error cleared", {31'd0, cfg_err}, 32'd0);
        chk("R4 idle high", {31'd0, sck}, 32'd1);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule